// File: doc/BRIEF.md
# 64-bit Event Timer with Register Access

This block is a bus-programmable up-counting timer that produces tick events for a processor. Software reaches it through a flat word-addressed register port: an address, a write strobe, write data and read data. A single interrupt line signals each event. The counter and its compare period are both 64 bits wide, and each is accessed as two 32-bit halves.

Software first releases the timer from reset through a global control register. It then loads the counter and the period, enables the interrupt and writes a two-bit enable-mode field in the timer control register. In one-shot mode the timer raises a single event and then disables itself. In periodic mode it reloads from zero on every match and keeps running. A sticky status flag records each event until software clears it by writing a one. Reads are registered and return one clock after the address is presented.

Top module: `evt_timer64`

## Requirements
- R1: After synchronous reset, every register reads 0, the counter is 0 and `irq_o` is 0.
- R2: Byte offsets: 0x10 counter bits [31:0], 0x14 counter bits [63:32], 0x18 period bits [31:0], 0x1C period bits [63:32], 0x20 timer control, 0x24 global control (bits [1:0] stored, upper bits read 0), 0x44 interrupt control/status. `reg_rdata` shows the addressed register one clock after the address is applied. Counter offsets return the live count, and any other offset reads 0.
- R3: Until global control bits [1:0] are both 1, the timer is held in reset. The counter stays 0, counter writes are ignored, and no counting or event takes place.
- R4: Timer control bits [7:6] select the mode: 00 off, 01 one-shot, 10 periodic, 11 off. In either running mode the 64-bit counter rises by one per clock from its current value, and the carry propagates from the low half into the high half.
- R5: When the running counter equals the 64-bit period, an event occurs and the counter wraps to 0. A count starting from 0 therefore produces an event every period+1 clocks.
- R6: In periodic mode, counting continues after each event.
- R7: In one-shot mode, an event clears bits [7:6] to 00, keeps every other control bit, and stops the counter at 0.
- R8: Writing 00 into bits [7:6] stops the counter and holds its value, and the other control bits keep the values written.
- R9: An event sets status bit 1 of register 0x44, which stays set until a write with bit 1 = 1 clears it. If an event and such a clear fall in the same clock, the flag stays set.
- R10: `irq_o` is the registered AND of the status flag and enable bit 0 of register 0x44. It goes high on the clock edge that sets the flag, or on the edge that sets the enable while the flag is already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Byte address of the register |
| reg_wr | input | 1 | Write strobe, one clock per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The critical collision is a timer match landing on the same clock edge as a software write that clears the status flag. The bench starts a periodic count from zero with a short period, counts clocks so that the clear write falls exactly on the fourth-cycle match edge, and then requires `irq_o` to stay high. A second clear, placed one clock later, must drop it. The same test also covers a match that lands while the enable bit is low: the flag must read back as set while `irq_o` stays low, until the enable is written.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  localparam int ADDR_W   = 8;
  localparam int GCTL_W   = 2;
  localparam int MODE_LSB = 6;

  localparam logic [ADDR_W-1:0] OFF_CNT_LO = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_CNT_HI = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_PRD_LO = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_PRD_HI = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_TCTL   = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_GCTL   = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_INT    = 8'h44;

  typedef enum logic [1:0] {
    MODE_OFF      = 2'b00,
    MODE_ONESHOT  = 2'b01,
    MODE_PERIODIC = 2'b10,
    MODE_RSVD     = 2'b11
  } mode_e;

endpackage

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
  import evt_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                hit,
  output logic [DATA_W-1:0]   tctl_q,
  output logic [GCTL_W-1:0]   gctl_q,
  output logic [2*DATA_W-1:0] prd_q,
  output logic                released,
  output logic                run,
  output logic                cnt_lo_wr,
  output logic                cnt_hi_wr,
  output logic                int_wr
);

  localparam int HALVES = 2;

  mode_e mode;
  logic  tctl_wr;
  logic  gctl_wr;

  assign tctl_wr   = wr_en && (addr == OFF_TCTL);
  assign gctl_wr   = wr_en && (addr == OFF_GCTL);
  assign cnt_lo_wr = wr_en && (addr == OFF_CNT_LO);
  assign cnt_hi_wr = wr_en && (addr == OFF_CNT_HI);
  assign int_wr    = wr_en && (addr == OFF_INT);

  assign mode     = mode_e'(tctl_q[MODE_LSB+1:MODE_LSB]);
  assign released = &gctl_q;
  assign run      = released && ((mode == MODE_ONESHOT) || (mode == MODE_PERIODIC));

  // Period halves: one word register per half, offsets four bytes apart.
  for (genvar h = 0; h < HALVES; h++) begin : g_prd
    localparam logic [ADDR_W-1:0] HALF_OFF = OFF_PRD_LO + ADDR_W'(4 * h);
    logic half_wr;
    assign half_wr = wr_en && (addr == HALF_OFF);
    always_ff @(posedge clk) begin
      if (rst) begin
        prd_q[h*DATA_W +: DATA_W] <= '0;
      end else if (half_wr) begin
        prd_q[h*DATA_W +: DATA_W] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gctl_q <= '0;
    end else if (gctl_wr) begin
      gctl_q <= wdata[GCTL_W-1:0];
    end
  end

  // Software write wins over a one-shot self-clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      tctl_q <= '0;
    end else if (tctl_wr) begin
      tctl_q <= wdata;
    end else if (hit && (mode == MODE_ONESHOT)) begin
      tctl_q[MODE_LSB+1:MODE_LSB] <= MODE_OFF;
    end
  end

  p_oneshot_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (hit && (mode == MODE_ONESHOT) && !tctl_wr)
      |=> ((mode == MODE_OFF) && $stable(tctl_q[MODE_LSB-1:0])
           && $stable(tctl_q[DATA_W-1:MODE_LSB+2])))
    else $error("one-shot event did not clear the mode field cleanly");

endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core #(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                released,
  input  logic                run,
  input  logic                cnt_lo_wr,
  input  logic                cnt_hi_wr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [2*DATA_W-1:0] prd,
  output logic [2*DATA_W-1:0] cnt_q,
  output logic                hit
);

  localparam int CNT_W = 2 * DATA_W;

  logic [CNT_W-1:0] cnt_nxt;

  assign hit = run && (cnt_q == prd);

  always_comb begin
    cnt_nxt = cnt_q;
    if (run) begin
      cnt_nxt = hit ? '0 : cnt_q + CNT_W'(1);
    end
    if (cnt_lo_wr) begin
      cnt_nxt[DATA_W-1:0] = wdata;
    end
    if (cnt_hi_wr) begin
      cnt_nxt[CNT_W-1:DATA_W] = wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !released) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_nxt;
    end
  end

  p_hold_zero_r3: assert property (@(posedge clk) disable iff (rst)
    !released |=> (cnt_q == '0))
    else $error("counter moved while timer held in reset");

  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    (run && !hit && !cnt_lo_wr && !cnt_hi_wr)
      |=> (!released || (cnt_q == $past(cnt_q) + CNT_W'(1))))
    else $error("running counter did not advance by one");

  p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (hit && !cnt_lo_wr && !cnt_hi_wr) |=> (cnt_q == '0))
    else $error("counter did not wrap after a period match");

  p_stopped_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_lo_wr && !cnt_hi_wr) |=> (!released || $stable(cnt_q)))
    else $error("stopped counter changed");

endmodule

// File: rtl/evt_timer_irq.sv
module evt_timer_irq (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic int_wr,
  input  logic wr_en_bit,
  input  logic wr_clr_bit,
  output logic ien_q,
  output logic status_q,
  output logic irq_o
);

  logic ien_nxt;
  logic status_nxt;

  assign ien_nxt    = int_wr ? wr_en_bit : ien_q;
  // A new event takes priority over a same-cycle write-one-to-clear.
  assign status_nxt = hit || (status_q && !(int_wr && wr_clr_bit));

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q    <= 1'b0;
      status_q <= 1'b0;
      irq_o    <= 1'b0;
    end else begin
      ien_q    <= ien_nxt;
      status_q <= status_nxt;
      irq_o    <= status_nxt && ien_nxt;
    end
  end

  p_event_sets_r9: assert property (@(posedge clk) disable iff (rst)
    hit |=> status_q)
    else $error("event did not set the status flag");

  p_w1c_r9: assert property (@(posedge clk) disable iff (rst)
    (int_wr && wr_clr_bit && !hit) |=> !status_q)
    else $error("status flag survived a clear write");

  p_irq_gate_r10: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (ien_q && status_q))
    else $error("interrupt high without flag and enable");

endmodule

// File: rtl/evt_timer64.sv
module evt_timer64
  import evt_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);

  localparam int CNT_W = 2 * DATA_W;

  logic [DATA_W-1:0] tctl_q;
  logic [GCTL_W-1:0] gctl_q;
  logic [CNT_W-1:0]  prd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              released;
  logic              run;
  logic              cnt_lo_wr;
  logic              cnt_hi_wr;
  logic              int_wr;
  logic              hit;
  logic              ien_q;
  logic              status_q;
  logic [DATA_W-1:0] rd_mux;

  evt_timer_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .hit       (hit),
    .tctl_q    (tctl_q),
    .gctl_q    (gctl_q),
    .prd_q     (prd_q),
    .released  (released),
    .run       (run),
    .cnt_lo_wr (cnt_lo_wr),
    .cnt_hi_wr (cnt_hi_wr),
    .int_wr    (int_wr)
  );

  evt_timer_core #(.DATA_W(DATA_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .released  (released),
    .run       (run),
    .cnt_lo_wr (cnt_lo_wr),
    .cnt_hi_wr (cnt_hi_wr),
    .wdata     (reg_wdata),
    .prd       (prd_q),
    .cnt_q     (cnt_q),
    .hit       (hit)
  );

  evt_timer_irq u_irq (
    .clk        (clk),
    .rst        (rst),
    .hit        (hit),
    .int_wr     (int_wr),
    .wr_en_bit  (reg_wdata[0]),
    .wr_clr_bit (reg_wdata[1]),
    .ien_q      (ien_q),
    .status_q   (status_q),
    .irq_o      (irq_o)
  );

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      OFF_CNT_LO: rd_mux = cnt_q[DATA_W-1:0];
      OFF_CNT_HI: rd_mux = cnt_q[CNT_W-1:DATA_W];
      OFF_PRD_LO: rd_mux = prd_q[DATA_W-1:0];
      OFF_PRD_HI: rd_mux = prd_q[CNT_W-1:DATA_W];
      OFF_TCTL:   rd_mux = tctl_q;
      OFF_GCTL:   rd_mux = DATA_W'(gctl_q);
      OFF_INT:    rd_mux = DATA_W'({status_q, ien_q});
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      reg_rdata <= rd_mux;
    end
  end

endmodule

// File: tb/evt_timer64_tb_top.sv
module evt_timer64_tb_top;

  localparam logic [7:0] A_CLO = 8'h10;
  localparam logic [7:0] A_CHI = 8'h14;
  localparam logic [7:0] A_PLO = 8'h18;
  localparam logic [7:0] A_PHI = 8'h1C;
  localparam logic [7:0] A_CTL = 8'h20;
  localparam logic [7:0] A_GBL = 8'h24;
  localparam logic [7:0] A_INT = 8'h44;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int n_checks = 0;
  int n_fails  = 0;
  logic rd_issue = 1'b0;
  logic done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  evt_timer64 dut_i (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_o     (irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Driver tasks: entered and left at a falling edge.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_issue = 1'b1;
    @(negedge clk);
    rd_issue = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compares registered read data with the scoreboard queue.
  initial begin
    forever begin
      @(posedge clk);
      if (rd_issue) begin
        #2;
        if (exp_q.size() == 0) begin
          check("monitor queue underflow", 32'h1, 32'h0);
        end else begin
          check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    check("R1 irq after reset", 32'(irq_o), 32'h0);
    rd(A_CLO, 32'h0, "R1 counter low");
    rd(A_CTL, 32'h0, "R1 control");
    rd(A_GBL, 32'h0, "R1 global");
    rd(A_INT, 32'h0, "R1 interrupt reg");
    rd(A_PHI, 32'h0, "R1 period high");

    // R3 held in reset
    wr(A_CTL, 32'h80);
    wr(A_CLO, 32'h5);
    idle(3);
    rd(A_CLO, 32'h0, "R3 counter held at zero");
    rd(A_INT, 32'h0, "R3 no event while held");
    wr(A_CTL, 32'h0);
    wr(A_GBL, 32'h1);
    wr(A_CLO, 32'h7);
    rd(A_CLO, 32'h0, "R3 partial release still held");
    wr(A_GBL, 32'h3);
    rd(A_GBL, 32'h3, "R2 global readback");

    // R2 map and readback
    wr(A_PLO, 32'h1234_5678);
    wr(A_PHI, 32'h9ABC_DEF0);
    wr(A_CLO, 32'hAAAA_5555);
    wr(A_CHI, 32'h0000_0007);
    rd(A_PLO, 32'h1234_5678, "R2 period low");
    rd(A_PHI, 32'h9ABC_DEF0, "R2 period high");
    rd(A_CLO, 32'hAAAA_5555, "R2 counter low");
    rd(A_CHI, 32'h0000_0007, "R2 counter high");
    rd(8'h00, 32'h0, "R2 unmapped 0x00");
    rd(8'h40, 32'h0, "R2 unmapped 0x40");
    rd(8'h28, 32'h0, "R2 unmapped 0x28");

    // R4 carry into high half: one increment
    wr(A_CLO, 32'hFFFF_FFFF);
    wr(A_CHI, 32'h0);
    wr(A_PLO, 32'hFFFF_FFFF);
    wr(A_PHI, 32'hFFFF_FFFF);
    wr(A_CTL, 32'h40);
    wr(A_CTL, 32'h00);
    rd(A_CLO, 32'h0, "R4 carry low half");
    rd(A_CHI, 32'h1, "R4 carry high half");

    // R4 mode 11 does not count
    wr(A_CTL, 32'hC0);
    idle(3);
    wr(A_CTL, 32'h0);
    rd(A_CLO, 32'h0, "R4 mode 11 idle low");
    rd(A_CHI, 32'h1, "R4 mode 11 idle high");

    // R4 / R8: count ten clocks then stop with other bits kept
    wr(A_CHI, 32'h0);
    wr(A_CLO, 32'h0);
    wr(A_CTL, 32'h80);
    idle(9);
    wr(A_CTL, 32'h25);
    rd(A_CLO, 32'd10, "R4 ten increments");
    rd(A_CTL, 32'h25, "R8 other control bits kept");
    idle(2);
    rd(A_CLO, 32'd10, "R8 count held when off");

    // R5 / R7 one-shot against a period with a high half
    wr(A_INT, 32'h1);
    wr(A_PHI, 32'h1);
    wr(A_PLO, 32'h0);
    wr(A_CHI, 32'h0);
    wr(A_CLO, 32'hFFFF_FFFC);
    wr(A_CTL, 32'h4D);
    idle(4);
    check("R5 no event before match", 32'(irq_o), 32'h0);
    idle(1);
    check("R5 event on 64-bit match", 32'(irq_o), 32'h1);
    rd(A_CLO, 32'h0, "R5 wrap low");
    rd(A_CHI, 32'h0, "R5 wrap high");
    rd(A_CTL, 32'h0D, "R7 mode cleared other bits kept");
    idle(2);
    rd(A_CLO, 32'h0, "R7 stopped after one-shot");
    rd(A_INT, 32'h3, "R9 status and enable read");
    wr(A_INT, 32'h3);
    check("R9 clear drops irq", 32'(irq_o), 32'h0);
    rd(A_INT, 32'h1, "R9 status cleared");

    // R6 / R9 periodic, clear collides with an event
    wr(A_PHI, 32'h0);
    wr(A_PLO, 32'h3);
    wr(A_CTL, 32'h80);
    idle(3);
    check("R6 no event before fourth clock", 32'(irq_o), 32'h0);
    idle(1);
    check("R6 first periodic event", 32'(irq_o), 32'h1);
    idle(3);
    wr(A_INT, 32'h3);
    check("R9 event wins over same-cycle clear", 32'(irq_o), 32'h1);
    wr(A_INT, 32'h3);
    check("R9 clear without collision", 32'(irq_o), 32'h0);
    idle(2);
    check("R6 quiet between events", 32'(irq_o), 32'h0);
    idle(1);
    check("R6 third periodic event", 32'(irq_o), 32'h1);

    // R10 enable gating
    wr(A_INT, 32'h2);
    check("R10 disable and clear", 32'(irq_o), 32'h0);
    idle(3);
    check("R10 event masked by enable", 32'(irq_o), 32'h0);
    rd(A_INT, 32'h2, "R10 flag set while masked");
    wr(A_INT, 32'h1);
    check("R10 enable exposes pending flag", 32'(irq_o), 32'h1);
    wr(A_CTL, 32'h0);

    idle(3);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule